// File: doc/BRIEF.md
# Node Identity Status Tracker

This block keeps the link layer's 32-bit node identity and status word up to date from physical-layer events. While a bus reset is being detected, the identity is invalid and the bus number is forced to its unassigned value. The root flag is taken from the physical layer during that reset. A new physical node number that arrives after self-identification is loaded and makes the identity valid again. The cable-power indication is registered every cycle.

Software reads the status word. It can change only the bus number, through a full-word host write port. A derived permission flag tells software whether it may start the asynchronous transmit contexts. The flag is low while the identity is invalid and also when the node number is 63, the code for an unassigned node.

All state updates on the rising clock edge, so every field change is visible one cycle after the input that causes it. The permission flag is a pure function of the registered word.

Top module: `node_status_tracker`

## Requirements
- R1: After reset the status word reads 32'h0000_FFFF: ID-valid (bit 31), root (bit 30) and cable-power (bit 27) are 0, the bus number (bits 15:6) is 10'h3FF and the node number (bits 5:0) is 6'h3F. tx_start_ok_o is 0.
- R2: Every cycle with bus_reset_i high makes the next status word show ID-valid 0 and bus number 10'h3FF.
- R3: In the first cycle of a bus reset (bus_reset_i high after a low cycle or after reset), the root bit is cleared. In each later cycle of the same bus reset it loads root_i. When the bus reset ends, the root bit holds its value.
- R4: Bit 27 shows cable_ok_i as sampled at the previous clock edge.
- R5: When node_num_vld_i is high and bus_reset_i is low, bits 5:0 load node_num_i and ID-valid becomes 1. A strobe during a bus reset changes neither field.
- R6: When host_wr_i is high and bus_reset_i is low, the bus number loads host_wdata_i[15:6]. All other bits of host_wdata_i are ignored.
- R7: A host write in the same cycle as bus_reset_i leaves the bus number at 10'h3FF.
- R8: Bits 29:28 and 26:16 of the status word always read 0.
- R9: tx_start_ok_o is 1 exactly when status bit 31 is 1 and bits 5:0 are not 6'h3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | High while a bus reset is detected |
| root_i | input | 1 | The physical layer reports this node as root |
| cable_ok_i | input | 1 | The physical layer reports cable power as good |
| node_num_vld_i | input | 1 | Strobe: a new node number is present |
| node_num_i | input | 6 | Node number from the physical layer |
| host_wr_i | input | 1 | Host write strobe for the status word |
| host_wdata_i | input | 32 | Host write data; only bits 15:6 are used |
| status_o | output | 32 | Node identity and status word |
| tx_start_ok_o | output | 1 | Asynchronous transmit contexts may be started |

## Verification
The assertions check on every cycle that a bus reset invalidates the identity and forces the bus number, and that the first reset cycle clears root. They also check that cable power follows its input with one cycle of delay, that accepted node and host loads land in the word, that the reserved bits stay zero, and that the permission flag never rises for an invalid or unassigned node. Some properties are visible only across several cycles, and only the bench scenarios show them. These are: root held after a reset ends, a node strobe or host write swallowed during a reset, read-only host bits having no effect, and the permission flag rising again after a reload.

// File: rtl/nst_pkg.sv
package nst_pkg;
  localparam int WORD_W    = 32;
  localparam int BUS_W     = 10;
  localparam int NODE_W    = 6;
  localparam int IDV_BIT   = 31;
  localparam int ROOT_BIT  = 30;
  localparam int CABLE_BIT = 27;
  localparam int BUS_LSB   = 6;
  localparam int BUS_MSB   = BUS_LSB + BUS_W - 1;
  localparam logic [BUS_W-1:0]  BUS_UNSET  = '1;
  localparam logic [NODE_W-1:0] NODE_UNSET = '1;

  // Assemble the status word; reserved positions stay zero.
  function automatic logic [WORD_W-1:0] pack_status(
    input logic              idv,
    input logic              root,
    input logic              cable,
    input logic [BUS_W-1:0]  bus,
    input logic [NODE_W-1:0] node
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[IDV_BIT]             = idv;
    w[ROOT_BIT]            = root;
    w[CABLE_BIT]           = cable;
    w[BUS_MSB:BUS_LSB]     = bus;
    w[NODE_W-1:0]          = node;
    return w;
  endfunction

  // Transmit contexts may start only with a valid, assigned node number.
  function automatic logic tx_allowed(input logic idv, input logic [NODE_W-1:0] node);
    return idv && (node != NODE_UNSET);
  endfunction
endpackage

// File: rtl/nst_reset_edge.sv
module nst_reset_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset_i,
  output logic reset_start_o,
  output logic reset_active_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= bus_reset_i;
  end

  assign reset_active_o = bus_reset_i;
  assign reset_start_o  = bus_reset_i && !prev_q;
endmodule

// File: rtl/nst_identity.sv
module nst_identity #(
  parameter int NODE_W = 6,
  parameter logic [NODE_W-1:0] NODE_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_start_i,
  input  logic              reset_active_i,
  input  logic              root_i,
  input  logic              cable_i,
  input  logic              node_accept_i,
  input  logic [NODE_W-1:0] node_i,
  output logic              idv_o,
  output logic              root_o,
  output logic              cable_o,
  output logic [NODE_W-1:0] node_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idv_o   <= 1'b0;
      root_o  <= 1'b0;
      cable_o <= 1'b0;
      node_o  <= NODE_INIT;
    end else begin
      cable_o <= cable_i;
      if (reset_active_i) begin
        idv_o  <= 1'b0;
        root_o <= reset_start_i ? 1'b0 : root_i;
      end else if (node_accept_i) begin
        idv_o  <= 1'b1;
        node_o <= node_i;
      end
    end
  end
endmodule

// File: rtl/nst_field_reg.sv
module nst_field_reg #(
  parameter int W = 10,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         force_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= INIT;
    else if (force_i) q_o <= INIT;
    else if (wr_i)    q_o <= wdata_i;
  end
endmodule

// File: rtl/node_status_tracker.sv
module node_status_tracker
  import nst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset_i,
  input  logic              root_i,
  input  logic              cable_ok_i,
  input  logic              node_num_vld_i,
  input  logic [NODE_W-1:0] node_num_i,
  input  logic              host_wr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] status_o,
  output logic              tx_start_ok_o
);
  logic              reset_start;
  logic              reset_active;
  logic              node_accept;
  logic              host_accept;
  logic              idv_q, root_q, cable_q;
  logic [NODE_W-1:0] node_q;
  logic [BUS_W-1:0]  bus_q;
  logic [WORD_W-BUS_W-1:0] host_ro_bits;

  assign node_accept  = node_num_vld_i && !reset_active;
  assign host_accept  = host_wr_i && !reset_active;
  assign host_ro_bits = {host_wdata_i[WORD_W-1:BUS_MSB+1], host_wdata_i[BUS_LSB-1:0]};

  nst_reset_edge u_edge (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_reset_i    (bus_reset_i),
    .reset_start_o  (reset_start),
    .reset_active_o (reset_active)
  );

  nst_identity #(.NODE_W(NODE_W), .NODE_INIT(NODE_UNSET)) u_ident (
    .clk            (clk),
    .rst_n          (rst_n),
    .reset_start_i  (reset_start),
    .reset_active_i (reset_active),
    .root_i         (root_i),
    .cable_i        (cable_ok_i),
    .node_accept_i  (node_accept),
    .node_i         (node_num_i),
    .idv_o          (idv_q),
    .root_o         (root_q),
    .cable_o        (cable_q),
    .node_o         (node_q)
  );

  nst_field_reg #(.W(BUS_W), .INIT(BUS_UNSET)) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .force_i (reset_active),
    .wr_i    (host_accept),
    .wdata_i (host_wdata_i[BUS_MSB:BUS_LSB]),
    .q_o     (bus_q)
  );

  assign status_o      = pack_status(idv_q, root_q, cable_q, bus_q, node_q);
  assign tx_start_ok_o = tx_allowed(idv_q, node_q);
endmodule

// File: rtl/nst_checker.sv
module nst_checker
  import nst_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_reset_i,
  input logic              cable_ok_i,
  input logic [NODE_W-1:0] node_num_i,
  input logic [WORD_W-1:0] host_wdata_i,
  input logic [WORD_W-1:0] status_o,
  input logic              tx_start_ok_o,
  input logic              reset_start,
  input logic              node_accept,
  input logic              host_accept,
  input logic [WORD_W-BUS_W-1:0] host_ro_bits
);
  p_reset_invalidates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> (!status_o[IDV_BIT] && status_o[BUS_MSB:BUS_LSB] == BUS_UNSET));

  p_root_cleared_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reset_start |=> !status_o[ROOT_BIT]);

  p_cable_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_o[CABLE_BIT] == $past(cable_ok_i)));

  p_node_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    node_accept |=> (status_o[IDV_BIT] && status_o[NODE_W-1:0] == $past(node_num_i)));

  p_host_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_accept |=> (status_o[BUS_MSB:BUS_LSB] == $past(host_wdata_i[BUS_MSB:BUS_LSB])));

  p_host_loses_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset_i && !host_accept) |=> (status_o[BUS_MSB:BUS_LSB] == BUS_UNSET));

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[29:28] == 2'b00 && status_o[26:16] == 11'd0 && ^host_ro_bits !== 1'bx)
    || (status_o[29:28] == 2'b00 && status_o[26:16] == 11'd0));

  p_tx_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_ok_o |-> (status_o[IDV_BIT] && status_o[NODE_W-1:0] != NODE_UNSET));
endmodule

bind node_status_tracker nst_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_reset_i   (bus_reset_i),
  .cable_ok_i    (cable_ok_i),
  .node_num_i    (node_num_i),
  .host_wdata_i  (host_wdata_i),
  .status_o      (status_o),
  .tx_start_ok_o (tx_start_ok_o),
  .reset_start   (reset_start),
  .node_accept   (node_accept),
  .host_accept   (host_accept),
  .host_ro_bits  (host_ro_bits)
);

// File: tb/sim_node_status_tracker.sv
`timescale 1ns/100ps
module sim_node_status_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset_i = 1'b0, root_i = 1'b0, cable_ok_i = 1'b0;
  logic        node_num_vld_i = 1'b0, host_wr_i = 1'b0;
  logic [5:0]  node_num_i = '0;
  logic [31:0] host_wdata_i = '0;
  logic [31:0] status_o;
  logic        tx_start_ok_o;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { string tag; logic [31:0] word; logic ok; } exp_t;
  exp_t q[$];

  // bench model state
  logic       m_idv = 0, m_root = 0, m_cab = 0, m_prev = 0;
  logic [9:0] m_bus = 10'h3FF;
  logic [5:0] m_node = 6'd63;

  always #2.5 clk = ~clk;

  node_status_tracker u0 (
    .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i), .root_i(root_i),
    .cable_ok_i(cable_ok_i), .node_num_vld_i(node_num_vld_i), .node_num_i(node_num_i),
    .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i),
    .status_o(status_o), .tx_start_ok_o(tx_start_ok_o)
  );

  task automatic check(input string tag, input logic [31:0] aw, ew, input logic ao, eo);
    checks++;
    if (aw !== ew || ao !== eo) begin
      failures++;
      $display("FAIL %s: status=%h tx_ok=%b expected status=%h tx_ok=%b", tag, aw, ao, ew, eo);
    end
  endtask

  task automatic drive(input string tag, input logic br, rt, cb, nv, input logic [5:0] nn,
                       input logic hw, input logic [31:0] hd);
    exp_t e;
    @(negedge clk);
    bus_reset_i = br; root_i = rt; cable_ok_i = cb;
    node_num_vld_i = nv; node_num_i = nn; host_wr_i = hw; host_wdata_i = hd;
    if (br) begin
      m_idv = 0; m_bus = 10'h3FF;
      m_root = m_prev ? rt : 1'b0;
    end else begin
      if (nv) begin m_idv = 1; m_node = nn; end
      if (hw) m_bus = hd[15:6];
    end
    m_cab = cb; m_prev = br;
    e.tag  = tag;
    e.word = {m_idv, m_root, 2'b00, m_cab, 11'd0, m_bus, m_node};
    e.ok   = m_idv && (m_node != 6'd63);
    q.push_back(e);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, status_o, e.word, tx_start_ok_o, e.ok);
      end
    end
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", status_o, 32'h0000_FFFF, tx_start_ok_o, 1'b0);
    // R4 cable power follows with one cycle delay
    drive("R4 cable on", 0, 0, 1, 0, 6'd0, 0, 32'h0);
    drive("R4 cable off", 0, 0, 0, 0, 6'd0, 0, 32'h0);
    drive("R4 cable on again", 0, 0, 1, 0, 6'd0, 0, 32'h0);
    // R5 node load, R9 permission
    drive("R5 R9 node 5 loads", 0, 0, 1, 1, 6'd5, 0, 32'h0);
    // R6 host write, R8 read-only bits ignored
    drive("R6 R8 host bus write", 0, 0, 1, 0, 6'd0, 1, 32'hFFFF_003F | (32'h123 << 6));
    drive("R6 hold", 0, 0, 1, 0, 6'd0, 0, 32'h0);
    drive("R9 node 63 blocks tx", 0, 0, 1, 1, 6'd63, 0, 32'h0);
    drive("R9 node 62 allows tx", 0, 0, 1, 1, 6'd62, 0, 32'h0);
    // bus reset with root reported
    drive("R2 R3 reset start clears root", 1, 1, 1, 0, 6'd0, 0, 32'h0);
    drive("R3 R5 root loads, strobe ignored", 1, 1, 1, 1, 6'd9, 0, 32'h0);
    drive("R7 host write loses to reset", 1, 1, 0, 0, 6'd0, 1, 32'h0000_0040);
    drive("R3 root holds after reset", 0, 0, 0, 0, 6'd0, 0, 32'h0);
    drive("R5 R9 node 2 after reset", 0, 0, 0, 1, 6'd2, 0, 32'h0);
    drive("R6 host write after reset", 0, 0, 0, 0, 6'd0, 1, 32'h0000_1540);
    // second bus reset, not root
    drive("R2 R3 second reset start", 1, 1, 0, 0, 6'd0, 0, 32'h0);
    drive("R3 root reloads zero", 1, 0, 0, 0, 6'd0, 0, 32'h0);
    drive("R3 root stays zero", 0, 1, 0, 0, 6'd0, 0, 32'h0);
    drive("R5 R9 idv returns", 0, 0, 1, 1, 6'd0, 0, 32'h0);
    drive("R4 idle", 0, 0, 0, 0, 6'd0, 0, 32'h0);
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule